// File: doc/BRIEF.md
# Memory Operand Address Decoder

This block receives the bytes of an instruction's addressing section one at a time. The first of these bytes is the ModRM byte, and the upstream opcode stage raises a start strobe with it once that stage knows a ModRM byte is present. From the contents of ModRM, the block decides how many further bytes belong to the operand. The choices are:

- no further bytes;
- a scale/index/base (SIB) byte;
- one displacement byte;
- four displacement bytes;
- an SIB byte followed by displacement bytes.

The block takes each following byte as it arrives with its valid strobe. It ends with a one-cycle done pulse and reports the total byte count together with the decoded fields.

When the parse is complete, the block gives the register field, whether the operand is a register or a memory reference, and the base, index and scale selections. It also gives the sign-extended 32-bit displacement and an effective address. The effective address is formed from eight 32-bit register values supplied on an input bus. The register numbering is 0 = eax, 1 = ecx, 2 = edx, 3 = ebx, 4 = esp, 5 = ebp, 6 = esi, 7 = edi. Register k occupies bits 32k+31 down to 32k of the bus.

Top module: `modrm_addr_decoder`

## Requirements
- R1: A byte taken with `start` and `byte_valid` both high is the ModRM byte. Its bits 7:6 are the mode, bits 5:3 are `reg_field` and bits 2:0 are `rm_field`. With mode 0 and an r/m other than 4 or 5, the parse ends at that byte with length 1, and the r/m register is the base.
- R2: Mode 3 is register direct. The parse ends at ModRM with length 1 even when r/m is 4. `reg_direct` is 1, `base_valid` and `index_valid` are 0, and `eff_addr` is 0.
- R3: Mode 1 takes exactly one displacement byte. That byte is sign-extended to 32 bits on `disp` before it is added.
- R4: Mode 2 takes four displacement bytes, least significant byte first, and assembles them into `disp`.
- R5: When the mode is not 3 and r/m is 4, the next byte is an SIB byte. In that byte, bits 7:6 give the scale code, which shifts the index left by 0 to 3 places. Bits 5:3 give the index register and bits 2:0 give the base register.
- R6: An SIB index code of 4 means there is no index register. `index_valid` is 0 and the scaled term is 0.
- R7: Mode 0 with r/m 5 has no base register. Four displacement bytes follow, the length is 5, and `eff_addr` equals `disp`.
- R8: Mode 0 with an SIB base code of 5 has no base register. Four displacement bytes follow the SIB byte, and the length is 6.
- R9: `eff_addr` is base + (index << scale) + disp, taken modulo 2^32.
- R10: `done` is high for exactly the one cycle after the clock edge that takes the final byte. Cycles with `byte_valid` low inside a parse do not advance it. A byte taken without `start` while no parse is in progress is ignored, and the outputs hold until the next start.
- R11: A start byte that arrives while a parse is in progress abandons that parse and begins a new one at the start byte.
- R12: After reset, `done` is 0, `len` is 0 and `eff_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks the accompanying byte as ModRM |
| byte_valid | input | 1 | Byte strobe |
| byte_in | input | 8 | Instruction byte |
| regs_in | input | 256 | Eight 32-bit register values, register k at bits 32k+31:32k |
| done | output | 1 | One-cycle parse-complete pulse |
| len | output | 3 | Bytes consumed, 1 to 6 |
| reg_field | output | 3 | ModRM reg field |
| rm_field | output | 3 | ModRM r/m field |
| reg_direct | output | 1 | Register-direct operand |
| base_valid | output | 1 | A base register is used |
| base_sel | output | 3 | Base register number |
| index_valid | output | 1 | An index register is used |
| index_sel | output | 3 | Index register number |
| scale_sel | output | 2 | Index shift amount |
| disp | output | 32 | Sign-extended displacement |
| eff_addr | output | 32 | Effective address |

## Verification
If the length state machine takes a wrong branch, the error appears at the ports in the cycle right after the byte where the parse should have ended. Either `done` fails to pulse there, or it pulses early with a `len` that disagrees with the mode and r/m that were given. The displacement bytes give a second view: a wrong byte order or a missing sign extension appears on `disp` and `eff_addr` in the same cycle as `done`. Base and index selection errors show in `eff_addr` because every register value in the bench is distinct. Gaps, ignored bytes and restarts are checked in the cycle after the affected byte.

// File: rtl/modrm_dec_pkg.sv
package modrm_dec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SIB  = 2'd1,
        ST_DISP = 2'd2
    } parse_st_e;

    typedef enum logic [1:0] {
        MD_IND0   = 2'd0,
        MD_IND8   = 2'd1,
        MD_IND32  = 2'd2,
        MD_DIRECT = 2'd3
    } mode_e;

    localparam logic [2:0] RM_SIB_ESC = 3'd4;
    localparam logic [2:0] RM_NOBASE  = 3'd5;
    localparam logic [2:0] IDX_NONE   = 3'd4;
    localparam logic [2:0] SIB_NOBASE = 3'd5;
    localparam logic [2:0] WIDE_BYTES = 3'd4;

    typedef struct packed {
        mode_e      mode;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } modrm_t;

    typedef struct packed {
        logic [1:0] scale;
        logic [2:0] index;
        logic [2:0] base;
    } sib_t;

    typedef struct packed {
        logic       direct;
        logic       base_en;
        logic [2:0] base;
        logic       idx_en;
        logic [2:0] index;
        logic [1:0] scale;
    } amode_t;

    function automatic logic [2:0] disp_count(mode_e m);
        case (m)
            MD_IND8:  return 3'd1;
            MD_IND32: return WIDE_BYTES;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/modrm_parse_fsm.sv
module modrm_parse_fsm
    import modrm_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            byte_valid,
    input  logic [7:0]      byte_in,
    output logic            done,
    output logic [2:0]      len,
    output logic [2:0]      reg_f,
    output logic [2:0]      rm_f,
    output amode_t          am,
    output logic [XLEN-1:0] disp
);
    localparam int EXT_W = XLEN - 8;

    parse_st_e       st_q;
    mode_e           mode_q;
    logic [2:0]      left_q;
    logic            wide_q;
    logic            done_q;
    logic [2:0]      len_q;
    logic [2:0]      reg_q;
    logic [2:0]      rm_q;
    amode_t          am_q;
    logic [XLEN-1:0] disp_q;

    modrm_t mr;
    sib_t   sb;
    logic [2:0] mr_cnt;
    logic [2:0] sb_cnt;

    assign mr     = modrm_t'(byte_in);
    assign sb     = sib_t'(byte_in);
    assign mr_cnt = disp_count(mr.mode);
    assign sb_cnt = disp_count(mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= MD_IND0;
            left_q <= '0;
            wide_q <= 1'b0;
            done_q <= 1'b0;
            len_q  <= '0;
            reg_q  <= '0;
            rm_q   <= '0;
            am_q   <= '0;
            disp_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (byte_valid && start) begin
                len_q  <= 3'd1;
                reg_q  <= mr.reg_f;
                rm_q   <= mr.rm;
                mode_q <= mr.mode;
                disp_q <= '0;
                am_q   <= '0;
                wide_q <= (mr.mode == MD_IND32);
                if (mr.mode == MD_DIRECT) begin
                    am_q.direct <= 1'b1;
                    done_q      <= 1'b1;
                    st_q        <= ST_IDLE;
                end else if (mr.rm == RM_SIB_ESC) begin
                    st_q <= ST_SIB;
                end else if (mr.mode == MD_IND0 && mr.rm == RM_NOBASE) begin
                    left_q <= WIDE_BYTES;
                    wide_q <= 1'b1;
                    st_q   <= ST_DISP;
                end else begin
                    am_q.base_en <= 1'b1;
                    am_q.base    <= mr.rm;
                    left_q       <= mr_cnt;
                    if (mr_cnt == 3'd0) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q   <= ST_DISP;
                    end
                end
            end else if (byte_valid) begin
                case (st_q)
                    ST_SIB: begin
                        len_q      <= len_q + 3'd1;
                        am_q.scale <= sb.scale;
                        am_q.index <= sb.index;
                        am_q.idx_en <= (sb.index != IDX_NONE);
                        if (mode_q == MD_IND0 && sb.base == SIB_NOBASE) begin
                            left_q <= WIDE_BYTES;
                            wide_q <= 1'b1;
                            st_q   <= ST_DISP;
                        end else begin
                            am_q.base_en <= 1'b1;
                            am_q.base    <= sb.base;
                            left_q       <= sb_cnt;
                            if (sb_cnt == 3'd0) begin
                                done_q <= 1'b1;
                                st_q   <= ST_IDLE;
                            end else begin
                                st_q   <= ST_DISP;
                            end
                        end
                    end
                    ST_DISP: begin
                        len_q  <= len_q + 3'd1;
                        left_q <= left_q - 3'd1;
                        if (wide_q)
                            disp_q <= {byte_in, disp_q[XLEN-1:8]};
                        else
                            disp_q <= {{EXT_W{byte_in[7]}}, byte_in};
                        if (left_q == 3'd1) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done  = done_q;
    assign len   = len_q;
    assign reg_f = reg_q;
    assign rm_f  = rm_q;
    assign am    = am_q;
    assign disp  = disp_q;

endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
    import modrm_dec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input  amode_t               am,
    input  logic [XLEN-1:0]      disp,
    input  logic [NREG*XLEN-1:0] regs_flat,
    output logic [XLEN-1:0]      ea
);
    logic [XLEN-1:0] rf [NREG];
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] idx_term;

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign rf[k] = regs_flat[k*XLEN +: XLEN];
    end

    always_comb begin
        base_term = am.base_en ? rf[am.base] : '0;
        idx_term  = am.idx_en ? (rf[am.index] << am.scale) : '0;
        ea        = am.direct ? '0 : (base_term + idx_term + disp);
    end

endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
    import modrm_dec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    input  logic [NREG*XLEN-1:0] regs_in,
    output logic               done,
    output logic [2:0]         len,
    output logic [2:0]         reg_field,
    output logic [2:0]         rm_field,
    output logic               reg_direct,
    output logic               base_valid,
    output logic [2:0]         base_sel,
    output logic               index_valid,
    output logic [2:0]         index_sel,
    output logic [1:0]         scale_sel,
    output logic [XLEN-1:0]    disp,
    output logic [XLEN-1:0]    eff_addr
);
    amode_t am;

    modrm_parse_fsm #(.XLEN(XLEN)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .done       (done),
        .len        (len),
        .reg_f      (reg_field),
        .rm_f       (rm_field),
        .am         (am),
        .disp       (disp)
    );

    modrm_ea_calc #(.XLEN(XLEN), .NREG(NREG)) u_ea (
        .am        (am),
        .disp      (disp),
        .regs_flat (regs_in),
        .ea        (eff_addr)
    );

    assign reg_direct  = am.direct;
    assign base_valid  = am.base_en;
    assign base_sel    = am.base;
    assign index_valid = am.idx_en;
    assign index_sel   = am.index;
    assign scale_sel   = am.scale;

endmodule

// File: rtl/modrm_addr_decoder_chk.sv
module modrm_addr_decoder_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            byte_valid,
    input logic            done,
    input logic [2:0]      len,
    input logic            reg_direct,
    input logic            base_valid,
    input logic            index_valid,
    input logic [XLEN-1:0] disp,
    input logic [XLEN-1:0] eff_addr
);
    p_len_range_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (len >= 3'd1 && len <= 3'd6));

    p_done_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(byte_valid));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(done) && !$past(byte_valid)) |-> ($stable(len) && $stable(disp)));

    p_direct_short_r2: assert property (@(posedge clk) disable iff (rst)
        (done && reg_direct) |-> (len == 3'd1 && !base_valid && !index_valid && eff_addr == '0));

    p_nobase_len_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !reg_direct && !base_valid) |-> (len >= 3'd5));

    p_abs_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !reg_direct && !base_valid && !index_valid) |-> (eff_addr == disp));

    p_index_needs_sib_r5: assert property (@(posedge clk) disable iff (rst)
        (done && index_valid) |-> (len >= 3'd2 && !reg_direct));

endmodule

bind modrm_addr_decoder modrm_addr_decoder_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_valid  (byte_valid),
    .done        (done),
    .len         (len),
    .reg_direct  (reg_direct),
    .base_valid  (base_valid),
    .index_valid (index_valid),
    .disp        (disp),
    .eff_addr    (eff_addr)
);

// File: tb/sim_modrm_addr_decoder.sv
`timescale 1ns/1ps
module sim_modrm_addr_decoder;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_in = 8'h00;
    logic [255:0] regs_in;
    logic         done;
    logic [2:0]   len;
    logic [2:0]   reg_field, rm_field, base_sel, index_sel;
    logic         reg_direct, base_valid, index_valid;
    logic [1:0]   scale_sel;
    logic [31:0]  disp, eff_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    for (genvar k = 0; k < 8; k++) begin : g_regs
        assign regs_in[k*32 +: 32] = 32'h1000 * (k + 1);
    end

    modrm_addr_decoder u0 (
        .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
        .byte_in(byte_in), .regs_in(regs_in), .done(done), .len(len),
        .reg_field(reg_field), .rm_field(rm_field), .reg_direct(reg_direct),
        .base_valid(base_valid), .base_sel(base_sel), .index_valid(index_valid),
        .index_sel(index_sel), .scale_sel(scale_sel), .disp(disp), .eff_addr(eff_addr)
    );

    typedef struct packed {
        logic [47:0] bytes;
        logic [2:0]  nb;
        logic [2:0]  len;
        logic        direct;
        logic [2:0]  regf;
        logic [31:0] ea;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{48'h11_00_00_00_00_00, 3'd1, 3'd1, 1'b0, 3'd2, 32'h0000_2000},
        '{48'hC2_00_00_00_00_00, 3'd1, 3'd1, 1'b1, 3'd0, 32'h0000_0000},
        '{48'hE4_00_00_00_00_00, 3'd1, 3'd1, 1'b1, 3'd4, 32'h0000_0000},
        '{48'h4A_04_00_00_00_00, 3'd2, 3'd2, 1'b0, 3'd1, 32'h0000_3004},
        '{48'h4A_FC_00_00_00_00, 3'd2, 3'd2, 1'b0, 3'd1, 32'h0000_2FFC},
        '{48'h8A_78_56_34_12_00, 3'd5, 3'd5, 1'b0, 3'd1, 32'h1234_8678},
        '{48'h87_00_90_FF_FF_00, 3'd5, 3'd5, 1'b0, 3'd0, 32'h0000_1000},
        '{48'h05_EF_BE_AD_DE_00, 3'd5, 3'd5, 1'b0, 3'd0, 32'hDEAD_BEEF},
        '{48'h04_99_00_00_00_00, 3'd2, 3'd2, 1'b0, 3'd0, 32'h0001_2000},
        '{48'h04_21_00_00_00_00, 3'd2, 3'd2, 1'b0, 3'd0, 32'h0000_2000},
        '{48'h04_C5_10_00_00_00, 3'd6, 3'd6, 1'b0, 3'd0, 32'h0000_8010},
        '{48'h44_75_80_00_00_00, 3'd3, 3'd3, 1'b0, 3'd0, 32'h0001_3F80},
        '{48'h84_0B_01_00_00_80, 3'd6, 3'd6, 1'b0, 3'd0, 32'h8000_6001}
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2";
            3, 4:    return "R3";
            5:       return "R4";
            6:       return "R9";
            7:       return "R7";
            8:       return "R5";
            9:       return "R6";
            10:      return "R8";
            11:      return "R3 R5";
            default: return "R4 R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit s);
        @(negedge clk);
        byte_in = b; byte_valid = 1'b1; start = s;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_valid = 1'b0; start = 1'b0;
    endtask

    task automatic run_bytes(input logic [47:0] bs, input int n);
        for (int i = 0; i < n; i++) put(bs[8*(5-i) +: 8], i == 0);
        idle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(done == 1'b0, "R12", "done", 32'(done), 32'd0);
        check(len == 3'd0, "R12", "len", 32'(len), 32'd0);
        check(eff_addr == 32'd0, "R12", "eff_addr", eff_addr, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_bytes(VEC[i].bytes, int'(VEC[i].nb));
            check(done == 1'b1, vtag(i), "done", 32'(done), 32'd1);
            check(len == VEC[i].len, vtag(i), "len", 32'(len), 32'(VEC[i].len));
            check(reg_direct == VEC[i].direct, vtag(i), "direct", 32'(reg_direct), 32'(VEC[i].direct));
            check(reg_field == VEC[i].regf, vtag(i), "reg_field", 32'(reg_field), 32'(VEC[i].regf));
            check(eff_addr == VEC[i].ea, vtag(i), "eff_addr", eff_addr, VEC[i].ea);
            if (i == 4)
                check(disp == 32'hFFFF_FFFC, "R3", "sign-extended disp", disp, 32'hFFFF_FFFC);
            if (i == 5)
                check(disp == 32'h1234_5678, "R4", "little-endian disp", disp, 32'h1234_5678);
            if (i == 8) begin
                check(scale_sel == 2'd2, "R5", "scale_sel", 32'(scale_sel), 32'd2);
                check(index_sel == 3'd3 && index_valid, "R5", "index", 32'(index_sel), 32'd3);
                check(base_sel == 3'd1 && base_valid, "R5", "base", 32'(base_sel), 32'd1);
            end
            if (i == 9)
                check(index_valid == 1'b0, "R6", "index_valid", 32'(index_valid), 32'd0);
            if (i == 7 || i == 10)
                check(base_valid == 1'b0, "R7 R8", "base_valid", 32'(base_valid), 32'd0);
            @(negedge clk);
            check(done == 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
        end

        // R10: bytes without start while idle are ignored, outputs hold
        put(8'hFF, 1'b0);
        put(8'h4C, 1'b0);
        idle();
        check(done == 1'b0, "R10", "stray done", 32'(done), 32'd0);
        check(len == 3'd6, "R10", "len hold", 32'(len), 32'd6);
        check(eff_addr == 32'h8000_6001, "R10", "ea hold", eff_addr, 32'h8000_6001);

        // R10: gaps inside a parse do not advance it
        put(8'h4A, 1'b1);
        idle();
        idle();
        check(done == 1'b0, "R10", "done during gap", 32'(done), 32'd0);
        put(8'h04, 1'b0);
        idle();
        check(done == 1'b1, "R10", "done after gap", 32'(done), 32'd1);
        check(eff_addr == 32'h0000_3004, "R10", "ea after gap", eff_addr, 32'h0000_3004);

        // R11: restart while waiting for displacement bytes
        put(8'h8A, 1'b1);
        put(8'h11, 1'b0);
        put(8'h22, 1'b0);
        put(8'h11, 1'b1);
        idle();
        check(done == 1'b1, "R11", "done after restart", 32'(done), 32'd1);
        check(len == 3'd1, "R11", "len after restart", 32'(len), 32'd1);
        check(eff_addr == 32'h0000_2000, "R11", "ea after restart", eff_addr, 32'h0000_2000);

        // R11: restart while waiting for SIB
        put(8'h04, 1'b1);
        put(8'hC2, 1'b1);
        idle();
        check(reg_direct == 1'b1 && len == 3'd1, "R11", "restart from SIB", 32'(len), 32'd1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule